// File: doc/BRIEF.md
# Circular Receive Ring Packet Walker

The block keeps received frames in a circular region of an on-chip byte-wide SRAM and hands them out one at a time. A write side is given a frame length and a receive status word at the start of each frame. It stores a six-byte header followed by the frame bytes at its write cursor, and it counts the frame as pending once the last byte has landed. If the header and the bytes together would reach the protected boundary, the frame is discarded instead and a sticky overflow flag is raised.

A read side walks the ring from a saved next-packet address, which starts at the ring start after reset. It parses each header, then either streams the frame bytes out on a valid/ready byte port, clamped to a maximum frame size, or, when the status word does not carry the received-OK bit, emits a one-cycle invalid-packet pulse and skips the bytes. In both cases it then frees the space. Freeing moves the protected boundary to one byte before the next packet, or to the ring stop address when the next packet sits at the ring start, and it takes one from the pending count.

Top module: `rxring_walker`

## Requirements
- R1: Each stored packet is a header of six bytes, all fields little-endian: the next-packet address (2 bytes), then the byte count (2 bytes), then the status word (2 bytes). The frame bytes follow the header, and the next packet starts directly after the last frame byte. Frames are delivered in the order written, with their bytes in order.
- R2: After reset, the pending count is 0, `rx_empty` is 1, `overflow` is 0, `rx_bound` equals RING_STOP, `out_valid` and `wr_ready` are 0, and the first packet is read from RING_START.
- R3: A packet is delivered only when bit OK_BIT (default 7) of its status word is 1; every other status bit is ignored. Otherwise none of its bytes appear, `rx_bad` pulses for exactly one cycle with `out_valid` low, and its space is still freed.
- R4: The number of bytes delivered is the smaller of the stored byte count and MAX_FRAME.
- R5: On release, `rx_bound` becomes RING_STOP if the next-packet address equals RING_START, and the next-packet address minus one otherwise.
- R6: `pkt_cnt` rises by one when a frame is fully stored and falls by one when a packet is released. It saturates at 255 and ignores a decrement at 0. `rx_empty` is 1 exactly when the count is 0, and no byte is streamed while it is 0.
- R7: A frame is stored only if its length plus six is at most the number of bytes from the write cursor up to, but not including, `rx_bound`. Otherwise its bytes are accepted and discarded, the count and the cursor are unchanged, and `overflow` is set and stays set until reset.
- R8: Write and read addresses advance by one per byte and wrap from RING_STOP to RING_START, including inside a header.
- R9: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. `out_last` marks the final delivered byte of a frame.
- R10: A frame of length 0 with the OK bit set delivers no byte and no `rx_bad` pulse, and is released like any other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_start | input | 1 | Begin a frame; sampled only while the writer is idle |
| wr_len | input | 16 | Frame byte count, taken with wr_start |
| wr_status | input | 16 | Receive status word, taken with wr_start |
| wr_valid | input | 1 | Frame byte present on wr_data |
| wr_data | input | 8 | Frame byte |
| wr_ready | output | 1 | Writer accepts a frame byte this cycle |
| out_valid | output | 1 | Delivered byte present |
| out_data | output | 8 | Delivered byte |
| out_last | output | 1 | Final delivered byte of the frame |
| out_ready | input | 1 | Consumer takes the byte |
| rx_bad | output | 1 | One-cycle pulse when a packet without the OK bit is released |
| rx_empty | output | 1 | No packet pending |
| pkt_cnt | output | 8 | Pending packet count |
| overflow | output | 1 | Sticky: a frame was dropped for lack of space |
| rx_bound | output | AW | Protected boundary address |

## Verification
The properties assume that `wr_start` is raised only while the writer is idle, that a frame is followed by exactly `wr_len` bytes, and that `wr_len` never exceeds the ring size. The bench keeps to this by having one task send each frame: it pulses the start for one cycle, then offers exactly the stated number of bytes, each held until `wr_ready` is seen. The ring is sized so that the longest frame used fits once the ring is drained, and the lengths are chosen so that packets straddle the wrap point, land exactly on the ring start, and, while output is stalled, run into the boundary.

// File: rtl/rxring_walker.sv
module rxring_walker #(
  parameter int AW         = 11,
  parameter int RING_START = 0,
  parameter int RING_STOP  = 2047,
  parameter int MAX_FRAME  = 1518,
  parameter int OK_BIT     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic [15:0]   wr_len,
  input  logic [15:0]   wr_status,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  output logic          wr_ready,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last,
  input  logic          out_ready,
  output logic          rx_bad,
  output logic          rx_empty,
  output logic [7:0]    pkt_cnt,
  output logic          overflow,
  output logic [AW-1:0] rx_bound
);

  localparam logic [31:0]   L_START = 32'(RING_START);
  localparam logic [31:0]   L_STOP  = 32'(RING_STOP);
  localparam logic [31:0]   L_LEN   = L_STOP - L_START + 32'd1;
  localparam logic [AW-1:0] A_START = AW'(RING_START);
  localparam logic [AW-1:0] A_STOP  = AW'(RING_STOP);
  localparam logic [15:0]   MAXF    = 16'(MAX_FRAME);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a == A_STOP) ? A_START : a + 1'b1;
  endfunction

  logic [7:0] mem [2**AW];

  typedef enum logic [1:0] {W_IDLE, W_HDR, W_DATA, W_DROP} wst_t;
  typedef enum logic [1:0] {R_IDLE, R_HDR, R_DATA, R_REL} rst_t;

  wst_t          wst;
  rst_t          rst;
  logic [AW-1:0] wptr, wnext_q, rptr, npkt, bound;
  logic [15:0]   wlen_q, wrem, wstat_q;
  logic [2:0]    widx, ridx;
  logic [15:0]   h_next, h_len, rrem;
  logic [7:0]    h_stat_lo, hdr_byte, rbyte;
  logic          ok_q, commit, release_pkt;
  logic [31:0]   free_b, need, off;
  logic          fits;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic [15:0]   stat_w, hnext16, clamp_len;

  always_comb begin
    if (bound >= wptr) free_b = 32'(bound) - 32'(wptr);
    else               free_b = 32'(bound) - L_START + L_STOP - 32'(wptr) + 32'd1;
    need = 32'(wr_len) + 32'd6;
    off  = 32'(wptr) - L_START + need;
    if (off >= L_LEN) off = off - L_LEN;
  end
  assign fits = need <= free_b;

  assign hnext16 = 16'(wnext_q);
  always_comb begin
    case (widx)
      3'd0:    hdr_byte = hnext16[7:0];
      3'd1:    hdr_byte = hnext16[15:8];
      3'd2:    hdr_byte = wlen_q[7:0];
      3'd3:    hdr_byte = wlen_q[15:8];
      3'd4:    hdr_byte = wstat_q[7:0];
      default: hdr_byte = wstat_q[15:8];
    endcase
  end

  assign mem_we    = (wst == W_HDR) || (wst == W_DATA && wr_valid);
  assign mem_waddr = wptr;
  assign mem_wdata = (wst == W_HDR) ? hdr_byte : wr_data;
  assign wr_ready  = (wst == W_DATA) || (wst == W_DROP);
  assign commit    = (wst == W_HDR && widx == 3'd5 && wlen_q == 16'd0) ||
                     (wst == W_DATA && wr_valid && wrem == 16'd1);

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_waddr] <= mem_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wst      <= W_IDLE;
      wptr     <= A_START;
      wnext_q  <= A_START;
      wlen_q   <= '0;
      wrem     <= '0;
      wstat_q  <= '0;
      widx     <= '0;
      overflow <= 1'b0;
    end else begin
      case (wst)
        W_IDLE: if (wr_start) begin
          wlen_q  <= wr_len;
          wrem    <= wr_len;
          wstat_q <= wr_status;
          wnext_q <= AW'(L_START + off);
          widx    <= '0;
          if (fits) wst <= W_HDR;
          else begin
            overflow <= 1'b1;
            if (wr_len != 16'd0) wst <= W_DROP;
          end
        end
        W_HDR: begin
          wptr <= step(wptr);
          widx <= widx + 3'd1;
          if (widx == 3'd5) wst <= (wlen_q == 16'd0) ? W_IDLE : W_DATA;
        end
        W_DATA: if (wr_valid) begin
          wptr <= step(wptr);
          wrem <= wrem - 16'd1;
          if (wrem == 16'd1) wst <= W_IDLE;
        end
        default: if (wr_valid) begin
          wrem <= wrem - 16'd1;
          if (wrem == 16'd1) wst <= W_IDLE;
        end
      endcase
    end
  end

  assign rbyte       = mem[rptr];
  assign stat_w      = {rbyte, h_stat_lo};
  assign clamp_len   = (h_len > MAXF) ? MAXF : h_len;
  assign release_pkt = (rst == R_REL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst       <= R_IDLE;
      rptr      <= A_START;
      npkt      <= A_START;
      bound     <= A_STOP;
      ridx      <= '0;
      h_next    <= '0;
      h_len     <= '0;
      h_stat_lo <= '0;
      rrem      <= '0;
      ok_q      <= 1'b0;
    end else begin
      case (rst)
        R_IDLE: if (pkt_cnt != 8'd0) begin
          rptr <= npkt;
          ridx <= '0;
          rst  <= R_HDR;
        end
        R_HDR: begin
          rptr <= step(rptr);
          ridx <= ridx + 3'd1;
          case (ridx)
            3'd0: h_next[7:0]  <= rbyte;
            3'd1: h_next[15:8] <= rbyte;
            3'd2: h_len[7:0]   <= rbyte;
            3'd3: h_len[15:8]  <= rbyte;
            3'd4: h_stat_lo    <= rbyte;
            3'd5: begin
              ok_q <= stat_w[OK_BIT];
              rrem <= clamp_len;
              rst  <= (stat_w[OK_BIT] && h_len != 16'd0) ? R_DATA : R_REL;
            end
            default: ;
          endcase
        end
        R_DATA: if (out_ready) begin
          rptr <= step(rptr);
          rrem <= rrem - 16'd1;
          if (rrem == 16'd1) rst <= R_REL;
        end
        default: begin
          npkt  <= AW'(h_next);
          bound <= (AW'(h_next) == A_START) ? A_STOP : AW'(h_next) - 1'b1;
          rst   <= R_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pkt_cnt <= 8'd0;
    else begin
      case ({commit, release_pkt})
        2'b10: if (pkt_cnt != 8'hFF) pkt_cnt <= pkt_cnt + 8'd1;
        2'b01: if (pkt_cnt != 8'd0)  pkt_cnt <= pkt_cnt - 8'd1;
        2'b11: if (pkt_cnt == 8'd0)  pkt_cnt <= 8'd1;
        default: ;
      endcase
    end
  end

  assign out_valid = (rst == R_DATA);
  assign out_data  = rbyte;
  assign out_last  = (rrem == 16'd1);
  assign rx_bad    = release_pkt && !ok_q;
  assign rx_empty  = (pkt_cnt == 8'd0);
  assign rx_bound  = bound;

endmodule

// File: rtl/rxring_walker_chk.sv
module rxring_walker_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic          rx_bad,
  input logic [7:0]    pkt_cnt,
  input logic          overflow,
  input logic [AW-1:0] rx_bound,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr
);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_waddr != rx_bound));

  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_bad_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_bad |-> !out_valid);

  assert_no_stream_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (pkt_cnt != 8'd0));

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pkt_cnt) |-> (pkt_cnt == $past(pkt_cnt) + 8'd1 || pkt_cnt == $past(pkt_cnt) - 8'd1));

endmodule

bind rxring_walker rxring_walker_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .rx_bad(rx_bad), .pkt_cnt(pkt_cnt),
  .overflow(overflow), .rx_bound(rx_bound), .mem_we(mem_we), .mem_waddr(mem_waddr)
);

// File: tb/tb_rxring_walker.sv
`timescale 1ns/100ps
module tb_rxring_walker;
  localparam int AW = 7, START = 8, STOP = 71, MAXF = 20, RLEN = STOP - START + 1;
  localparam int NV = 10;
  localparam int VLEN [NV] = '{10, 25, 5, 12, 46, 0, 20, 21, 57, 1};
  localparam bit VOK  [NV] = '{1, 1, 0, 1, 1, 1, 1, 1, 1, 1};

  logic clk = 0, rst_n = 0;
  logic wr_start = 0, wr_valid = 0, out_ready = 1;
  logic [15:0] wr_len = 0, wr_status = 0;
  logic [7:0] wr_data = 0;
  logic wr_ready, out_valid, out_last, rx_bad, rx_empty, overflow;
  logic [7:0] out_data, pkt_cnt;
  logic [AW-1:0] rx_bound;

  rxring_walker #(.AW(AW), .RING_START(START), .RING_STOP(STOP), .MAX_FRAME(MAXF), .OK_BIT(7)) dut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_len(wr_len), .wr_status(wr_status),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready), .rx_bad(rx_bad),
    .rx_empty(rx_empty), .pkt_cnt(pkt_cnt), .overflow(overflow), .rx_bound(rx_bound));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, woff = 0, n_last = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] rx_q[$], exp_q[$];
  int exp_bad = 0;

  always @(negedge clk) if (rst_n) begin
    if (out_valid && out_ready) begin
      rx_q.push_back(out_data);
      if (out_last) n_last++;
    end
    if (rx_bad) n_bad++;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_bound();
    return (woff == 0) ? STOP : START + woff - 1;
  endfunction

  task automatic send_byte(logic [7:0] b);
    wr_valid = 1; wr_data = b;
    do @(negedge clk); while (!wr_ready);
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic put_frame(int len, bit ok, int seed, bit stored);
    @(posedge clk); #1;
    wr_start = 1; wr_len = 16'(len); wr_status = ok ? 16'h1280 : 16'hFF7F;
    @(posedge clk); #1;
    wr_start = 0;
    if (len == 0) begin repeat (6) @(posedge clk); #1; end
    else for (int i = 0; i < len; i++) send_byte(8'(seed + i));
    if (stored) begin
      woff = (woff + 6 + len) % RLEN;
      if (ok) for (int i = 0; i < (len < MAXF ? len : MAXF); i++) exp_q.push_back(8'(seed + i));
      else exp_bad++;
    end
  endtask

  task automatic drain();
    int n = 0;
    do begin @(negedge clk); n++; end while (!(rx_empty && !out_valid) && n < 3000);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_rx(string req, int frames);
    int mism = 0;
    check(req, rx_q.size(), exp_q.size());
    for (int i = 0; i < rx_q.size() && i < exp_q.size(); i++) if (rx_q[i] != exp_q[i]) mism++;
    check(req, mism, 0);
    check("R9 last", n_last, frames);
    check("R3 bad", n_bad, exp_bad);
    check("R5 bound", int'(rx_bound), exp_bound());
    check("R6 empty", int'(rx_empty), 1);
    rx_q.delete(); exp_q.delete(); n_last = 0; n_bad = 0; exp_bad = 0;
  endtask

  task automatic check_reset();
    @(negedge clk);
    check("R2 cnt", int'(pkt_cnt), 0);
    check("R2 empty", int'(rx_empty), 1);
    check("R2 overflow", int'(overflow), 0);
    check("R2 bound", int'(rx_bound), STOP);
    check("R2 out_valid", int'(out_valid), 0);
    check("R2 wr_ready", int'(wr_ready), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    check_reset();

    // R1 R3 R4 R5 R8 R10: frames walk the ring, wrap (4th), land on start (5th), zero length (6th)
    for (int v = 0; v < NV; v++) begin
      put_frame(VLEN[v], VOK[v], v * 37, 1);
      drain();
      check_rx("R1 R4 data", (VOK[v] && VLEN[v] != 0) ? 1 : 0);
      check("R7 no false overflow", int'(overflow), 0);
    end

    // R6 R7: stalled output, three frames pending, fourth hits boundary
    out_ready = 0;
    for (int k = 0; k < 3; k++) put_frame(10, 1, 100 + k * 16, 1);
    @(negedge clk);
    check("R6 pending count", int'(pkt_cnt), 3);
    check("R9 stalled valid", int'(out_valid), 1);
    check("R7 fits exactly", int'(overflow), 0);
    put_frame(10, 1, 200, 0);
    @(negedge clk);
    check("R7 overflow set", int'(overflow), 1);
    check("R7 count unchanged", int'(pkt_cnt), 3);
    out_ready = 1;
    drain();
    check_rx("R1 R7 order", 3);

    // R7: frame longer than free space on drained ring is dropped
    put_frame(RLEN - 6, 1, 50, 0);
    drain();
    check("R7 dropped", rx_q.size(), 0);
    check("R7 sticky", int'(overflow), 1);
    put_frame(8, 1, 77, 1);
    drain();
    check_rx("R7 after drop", 1);

    // R2: mid-run reset returns to start
    @(posedge clk); #1; rst_n = 0;
    repeat (2) @(posedge clk); #1; rst_n = 1;
    check_reset();
    woff = 0;
    put_frame(3, 1, 9, 1);
    drain();
    check_rx("R2 restart", 1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule